// File: doc/BRIEF.md
# Quarter-Word Multiply-Accumulate Unit

This block is the wide accumulator datapath of a big-number arithmetic engine. Each operation takes two 256-bit operands. It picks one 64-bit quarter-word out of each, forms the 128-bit product, and moves that product left by 0, 64, 128 or 192 bits. The aligned value is then added into a 256-bit accumulator. Any carry past bit 255 is dropped.

Modifiers on each operation control what happens around the add. The clear modifier starts the sum from zero instead of the current accumulator. The full-write mode sends the whole 256-bit sum to a destination register port. The shift-out mode sends the low 128 bits of the sum to one half of the destination and keeps the remaining upper half, moved down by 128 bits, as the new accumulator. A chain of such operations builds a 512-bit product out of 64-bit partial products with no separate add steps. Software can also read the accumulator and load it directly through a wide special-register path.

Top module: `qw_mac_unit`

## Requirements
- R1: After synchronous reset the accumulator reads zero and `dst_we` is 0.
- R2: Quarter index k on `sel_a`/`sel_b` selects bits [64k+63:64k] of `op_a`/`op_b`.
- R3: The 128-bit product is shifted left by 64 times `shift_q` (0..3), and bits that land above bit 255 are discarded, including when `shift_q` is 3.
- R4: An operation without clear sets the accumulator to the old accumulator plus the aligned product, modulo 2^256.
- R5: With `clear_first` set, the sum is formed from zero plus the aligned product and the old accumulator has no effect.
- R6: With `out_mode` = 2'b01 (full write), `dst_we` is 1 the next cycle, `dst_sel` is 2'b10, `dst_wdata` is the full sum, and the accumulator holds the sum.
- R7: With `out_mode` = 2'b10 (shift-out), `dst_wdata` carries sum[127:0] in the lower half when `out_half` is 0 (`dst_sel` = 2'b00), or in the upper half when `out_half` is 1 (`dst_sel` = 2'b01), with the other half zero. The accumulator becomes the sum shifted right by 128.
- R8: With `out_mode` = 2'b00 or 2'b11, the operation updates the accumulator and `dst_we` stays 0.
- R9: `acc_wr_en` without `op_valid` loads `acc_wr_data` into the accumulator, and `acc_rd_data` always shows the accumulator. When both are set, the operation wins and the direct write has no effect.
- R10: Results appear at the clock edge that samples `op_valid`, and `dst_we` is high for exactly that one following cycle.
- R11: With neither `op_valid` nor `acc_wr_en`, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Start one multiply-accumulate operation this cycle |
| op_a | input | 256 | First wide source operand |
| op_b | input | 256 | Second wide source operand |
| sel_a | input | 2 | Quarter-word index into op_a |
| sel_b | input | 2 | Quarter-word index into op_b |
| shift_q | input | 2 | Product shift in units of 64 bits |
| clear_first | input | 1 | Start the sum from zero |
| out_mode | input | 2 | 00 none, 01 full write, 10 shift-out, 11 none |
| out_half | input | 1 | Shift-out target half: 0 lower, 1 upper |
| acc_wr_en | input | 1 | Direct accumulator load |
| acc_wr_data | input | 256 | Value for the direct load |
| acc_rd_data | output | 256 | Current accumulator |
| dst_we | output | 1 | Destination register write enable |
| dst_sel | output | 2 | 00 lower half, 01 upper half, 10 full word |
| dst_wdata | output | 256 | Destination write data |

## Verification
The hardest condition to reach from the ports is a carry out of bit 255, combined with a product whose upper bits fall off the top at a 192-bit shift. Random operands almost never produce a carry out of a full 256-bit accumulator. Directed cases therefore load all-ones into the accumulator through the direct write port and then add a product of one, and they multiply all-ones quarter-words at the largest shift. A random phase with a fixed seed mixes every mode, index and shift, and interleaves the clear modifier so that chains of shift-out operations also run on accumulated state.

// File: rtl/qmac_pkg.sv
package qmac_pkg;

    parameter int unsigned WIDE_W = 256;
    parameter int unsigned QUART_W = 64;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'b00,
        OUT_FULL  = 2'b01,
        OUT_SHIFT = 2'b10,
        OUT_RSVD  = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        DST_LO  = 2'b00,
        DST_HI  = 2'b01,
        DST_ALL = 2'b10
    } dst_sel_e;

    typedef struct packed {
        logic      clear;
        out_mode_e mode;
        logic      hi;
    } op_ctrl_t;

    function automatic logic writes_dst(input out_mode_e m);
        return (m == OUT_FULL) || (m == OUT_SHIFT);
    endfunction

endpackage

// File: rtl/qw_select.sv
module qw_select #(
    parameter int unsigned W = qmac_pkg::WIDE_W,
    parameter int unsigned Q = qmac_pkg::QUART_W,
    localparam int unsigned NQ = W / Q,
    localparam int unsigned IW = $clog2(NQ)
) (
    input  logic [W-1:0]  src,
    input  logic [IW-1:0] idx,
    output logic [Q-1:0]  quarter
);
    logic [Q-1:0] parts [NQ];

    for (genvar k = 0; k < NQ; k++) begin : g_part
        assign parts[k] = src[k*Q +: Q];
    end

    assign quarter = parts[idx];
endmodule

// File: rtl/qw_product_align.sv
module qw_product_align #(
    parameter int unsigned W = qmac_pkg::WIDE_W,
    parameter int unsigned Q = qmac_pkg::QUART_W,
    localparam int unsigned NQ = W / Q,
    localparam int unsigned IW = $clog2(NQ),
    localparam int unsigned PW = 2 * Q
) (
    input  logic [Q-1:0]  a_q,
    input  logic [Q-1:0]  b_q,
    input  logic [IW-1:0] shift_q,
    output logic [W-1:0]  aligned
);
    logic [PW-1:0] prod;
    logic [W-1:0]  ext;
    logic [W-1:0]  steps [NQ];

    assign prod = {{Q{1'b0}}, a_q} * {{Q{1'b0}}, b_q};
    assign ext  = {{(W-PW){1'b0}}, prod};

    // one candidate per legal shift; upper product bits fall off the top
    for (genvar s = 0; s < NQ; s++) begin : g_shift
        if (s == 0) begin : g_zero
            assign steps[s] = ext;
        end else begin : g_move
            assign steps[s] = {ext[W-1-s*Q:0], {(s*Q){1'b0}}};
        end
    end

    assign aligned = steps[shift_q];
endmodule

// File: rtl/qw_acc_core.sv
module qw_acc_core
    import qmac_pkg::*;
#(
    parameter int unsigned W = qmac_pkg::WIDE_W,
    localparam int unsigned H = W / 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  op_ctrl_t     ctrl,
    input  logic [W-1:0] aligned,
    input  logic         acc_wr_en,
    input  logic [W-1:0] acc_wr_data,
    output logic [W-1:0] acc_q,
    output logic         dst_we,
    output logic [1:0]   dst_sel,
    output logic [W-1:0] dst_wdata
);
    logic [W-1:0] base;
    logic [W-1:0] sum;

    assign base = ctrl.clear ? '0 : acc_q;
    assign sum  = base + aligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            dst_we    <= 1'b0;
            dst_sel   <= DST_LO;
            dst_wdata <= '0;
        end else begin
            dst_we <= 1'b0;
            if (op_valid) begin
                dst_we <= writes_dst(ctrl.mode);
                unique case (ctrl.mode)
                    OUT_FULL: begin
                        acc_q     <= sum;
                        dst_sel   <= DST_ALL;
                        dst_wdata <= sum;
                    end
                    OUT_SHIFT: begin
                        acc_q     <= sum >> H;
                        dst_sel   <= ctrl.hi ? DST_HI : DST_LO;
                        dst_wdata <= ctrl.hi ? {sum[H-1:0], {H{1'b0}}}
                                             : {{H{1'b0}}, sum[H-1:0]};
                    end
                    default: begin
                        acc_q <= sum;
                    end
                endcase
            end else if (acc_wr_en) begin
                acc_q <= acc_wr_data;
            end
        end
    end

    // R11
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !acc_wr_en) |=> $stable(acc_q));
    // R9
    acc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && acc_wr_en) |=> (acc_q == $past(acc_wr_data)));
    // R7
    shiftout_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ctrl.mode == OUT_SHIFT) |=> (acc_q[W-1:H] == '0));
    // R8
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (ctrl.mode == OUT_NONE || ctrl.mode == OUT_RSVD)) |=> !dst_we);
    // R10
    dst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> $past(op_valid));
    // R6
    full_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ctrl.mode == OUT_FULL) |=>
            (dst_we && dst_sel == DST_ALL && dst_wdata == acc_q));
endmodule

// File: rtl/qw_mac_unit.sv
module qw_mac_unit
    import qmac_pkg::*;
#(
    parameter int unsigned W = qmac_pkg::WIDE_W,
    parameter int unsigned Q = qmac_pkg::QUART_W,
    localparam int unsigned NQ = W / Q,
    localparam int unsigned IW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [IW-1:0] sel_a,
    input  logic [IW-1:0] sel_b,
    input  logic [IW-1:0] shift_q,
    input  logic          clear_first,
    input  logic [1:0]    out_mode,
    input  logic          out_half,
    input  logic          acc_wr_en,
    input  logic [W-1:0]  acc_wr_data,
    output logic [W-1:0]  acc_rd_data,
    output logic          dst_we,
    output logic [1:0]    dst_sel,
    output logic [W-1:0]  dst_wdata
);
    logic [Q-1:0] qa;
    logic [Q-1:0] qb;
    logic [W-1:0] aligned;
    op_ctrl_t     ctrl;

    assign ctrl.clear = clear_first;
    assign ctrl.mode  = out_mode_e'(out_mode);
    assign ctrl.hi    = out_half;

    qw_select #(.W(W), .Q(Q)) i_sel_a (.src(op_a), .idx(sel_a), .quarter(qa));
    qw_select #(.W(W), .Q(Q)) i_sel_b (.src(op_b), .idx(sel_b), .quarter(qb));

    qw_product_align #(.W(W), .Q(Q)) i_align (
        .a_q(qa), .b_q(qb), .shift_q(shift_q), .aligned(aligned)
    );

    qw_acc_core #(.W(W)) i_core (
        .clk(clk), .rst(rst), .op_valid(op_valid), .ctrl(ctrl),
        .aligned(aligned), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
        .acc_q(acc_rd_data), .dst_we(dst_we), .dst_sel(dst_sel),
        .dst_wdata(dst_wdata)
    );
endmodule

// File: tb/test_qw_mac_unit.sv
module test_qw_mac_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [255:0] op_a = '0, op_b = '0;
    logic [1:0]   sel_a = '0, sel_b = '0, shift_q = '0;
    logic         clear_first = 1'b0;
    logic [1:0]   out_mode = '0;
    logic         out_half = 1'b0;
    logic         acc_wr_en = 1'b0;
    logic [255:0] acc_wr_data = '0;
    logic [255:0] acc_rd_data;
    logic         dst_we;
    logic [1:0]   dst_sel;
    logic [255:0] dst_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [255:0] m_acc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qw_mac_unit i_qw_mac_unit (
        .clk, .rst, .op_valid, .op_a, .op_b, .sel_a, .sel_b, .shift_q,
        .clear_first, .out_mode, .out_half, .acc_wr_en, .acc_wr_data,
        .acc_rd_data, .dst_we, .dst_sel, .dst_wdata
    );

    function automatic logic [255:0] rand256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] model_aligned(logic [255:0] a, logic [255:0] b,
                                                   logic [1:0] sa, logic [1:0] sb,
                                                   logic [1:0] sh);
        logic [127:0] p;
        logic [255:0] e;
        p = {64'd0, a[sa*64 +: 64]} * {64'd0, b[sb*64 +: 64]};
        e = {128'd0, p};
        return e << (int'(sh) * 64);
    endfunction

    task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [255:0] a, logic [255:0] b, logic [1:0] sa,
                          logic [1:0] sb, logic [1:0] sh, logic clr,
                          logic [1:0] mode, logic hi, logic wr, string tag);
        logic [255:0] sum, exp_acc, exp_data;
        logic [1:0]   exp_sel;
        logic         exp_we;
        sum      = (clr ? 256'd0 : m_acc) + model_aligned(a, b, sa, sb, sh);
        exp_we   = (mode == 2'b01) || (mode == 2'b10);
        exp_acc  = sum;
        exp_sel  = 2'b10;
        exp_data = sum;
        if (mode == 2'b10) begin
            exp_acc  = sum >> 128;
            exp_sel  = hi ? 2'b01 : 2'b00;
            exp_data = hi ? {sum[127:0], 128'd0} : {128'd0, sum[127:0]};
        end
        op_a = a; op_b = b; sel_a = sa; sel_b = sb; shift_q = sh;
        clear_first = clr; out_mode = mode; out_half = hi;
        acc_wr_en = wr; acc_wr_data = ~m_acc;
        op_valid = 1'b1;
        @(posedge clk); #1;
        op_valid = 1'b0; acc_wr_en = 1'b0;
        m_acc = exp_acc;
        chk({tag, " acc"}, acc_rd_data, exp_acc);
        chk({tag, " R10 we"}, {255'd0, dst_we}, {255'd0, exp_we});
        if (exp_we) begin
            chk({tag, " sel"}, {254'd0, dst_sel}, {254'd0, exp_sel});
            chk({tag, " data"}, dst_wdata, exp_data);
        end
    endtask

    task automatic load_acc(logic [255:0] d);
        acc_wr_en = 1'b1; acc_wr_data = d;
        @(posedge clk); #1;
        acc_wr_en = 1'b0;
        m_acc = d;
        chk("R9 direct load", acc_rd_data, d);
    endtask

    task automatic idle_check();
        @(posedge clk); #1;
        chk("R11 hold", acc_rd_data, m_acc);
        chk("R10 we single cycle", {255'd0, dst_we}, 256'd0);
    endtask

    initial begin
        logic [255:0] ones;
        ones = '1;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1 reset acc", acc_rd_data, 256'd0);
        chk("R1 reset we", {255'd0, dst_we}, 256'd0);

        // R2 quarter selection with distinct quarters
        run_op({64'd7, 64'd5, 64'd3, 64'd2}, {64'd13, 64'd11, 64'd19, 64'd17},
               2'd2, 2'd3, 2'd0, 1'b1, 2'b01, 1'b0, 1'b0, "R2 R6");
        run_op({64'd7, 64'd5, 64'd3, 64'd2}, {64'd13, 64'd11, 64'd19, 64'd17},
               2'd3, 2'd0, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0, "R2 R4 R8");
        idle_check();
        // R3 largest shift with truncation of product upper bits
        run_op(ones, ones, 2'd1, 2'd2, 2'd3, 1'b1, 2'b01, 1'b0, 1'b0, "R3 R5");
        run_op(ones, ones, 2'd0, 2'd0, 2'd2, 1'b0, 2'b11, 1'b0, 1'b0, "R3 R8 rsvd");
        // R4 carry out of bit 255 is discarded
        load_acc(ones);
        run_op(256'd1, 256'd1, 2'd0, 2'd0, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0, "R4 wrap");
        // R5 clear ignores a nonzero accumulator
        load_acc(rand256());
        run_op(256'd9, 256'd4, 2'd0, 2'd0, 2'd0, 1'b1, 2'b01, 1'b0, 1'b0, "R5 clear");
        // R7 shift-out chain into lower then upper half
        load_acc(rand256());
        run_op(ones, ones, 2'd3, 2'd3, 2'd1, 1'b0, 2'b10, 1'b0, 1'b0, "R7 lower");
        run_op(ones, ones, 2'd2, 2'd1, 2'd0, 1'b0, 2'b10, 1'b1, 1'b0, "R7 upper");
        // R9 op has priority over a simultaneous direct write
        run_op(rand256(), rand256(), 2'd1, 2'd1, 2'd2, 1'b0, 2'b00, 1'b0, 1'b1, "R9 priority");
        idle_check();

        for (int n = 0; n < 400; n++) begin
            if (($urandom % 16) == 0) load_acc(rand256());
            run_op(rand256(), rand256(), 2'($urandom), 2'($urandom), 2'($urandom),
                   1'(($urandom % 5) == 0), 2'($urandom), 1'($urandom),
                   1'(($urandom % 6) == 0), "R4 random");
            if (($urandom % 8) == 0) idle_check();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule